// File: doc/BRIEF.md
# Selectable Latency Synchronous Memory Port

This block is one synchronous access port onto a word-wide memory whose word is split into four equal byte lanes (9 bits each by default, 36 bits in total). Address, chip enable, read/write control, per-lane selects and write data are all captured on the rising clock. A write stores only the lanes whose select is active. A read returns the selected lanes of the addressed word.

A static mode input picks the read latency. With the mode input low, the port runs in flow-through mode: read data comes straight from the array in the cycle after the edge that captured the address. With the mode input high, the port runs in pipelined mode: an extra output register delays the data, the deselection and the reactivation by one more clock.

Tri-state drive is modelled as a per-bit drive mask (`rdata_en_o`). Any bit that is not driven reads as zero on `rdata_o`. The output enable gates that mask at once, with no clock involved. The port keeps its own behavioural storage, so it needs nothing else to run. An address counter or a bus-width adapter can sit in front of it.

Top module: `sync_mem_port`

## Requirements
- R1: With `pipe_mode_i` = 0, a read sampled at rising edge k (`ce_ni`=0, `we_ni`=1) drives its data and drive mask on the outputs from edge k until edge k+1.
- R2: With `pipe_mode_i` = 1, a read sampled at edge k drives its outputs from edge k+1 until edge k+2.
- R3: A write sampled at an edge (`ce_ni`=0, `we_ni`=0) stores `wdata_i` into each lane whose select bit `sel_ni[i]` is 0. Lane i covers bits i*9 to i*9+8. Lanes whose select bit is 1 keep their stored value.
- R4: On a read, lane i is driven (all 9 bits of `rdata_en_o` for that lane are 1) only when `sel_ni[i]` was 0 at the sampling edge. The other lanes have all mask bits at 0.
- R5: A clock edge with `ce_ni`=1 leaves every output bit undriven in the output window of that edge: the next cycle in flow-through mode, one cycle later in pipelined mode. Leaving deselection takes effect with the same delay.
- R6: A write cycle leaves every output bit undriven in the output window of that cycle.
- R7: While `oe_ni`=1, `rdata_en_o` and `rdata_o` are all zero, at once and with no clock edge. Dropping `oe_ni` restores the current drive at once.
- R8: While `rst_ni`=0, and until the first read reaches the outputs, no output bit is driven.
- R9: Every undriven output bit reads 0 on `rdata_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Rising-edge clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pipe_mode_i | input | 1 | 0: flow-through, 1: pipelined; static between resets |
| ce_ni | input | 1 | Chip enable, active low, sampled |
| we_ni | input | 1 | 0: write, 1: read; sampled |
| sel_ni | input | LANES (4) | Per-lane select, active low, sampled |
| addr_i | input | ADDR_W (6) | Word address, sampled |
| wdata_i | input | LANES*LANE_W (36) | Write data, sampled |
| oe_ni | input | 1 | Output enable, active low, asynchronous |
| rdata_o | output | LANES*LANE_W (36) | Read data, zero where not driven |
| rdata_en_o | output | LANES*LANE_W (36) | Per-bit drive mask, 1 = driven |

## Verification
The bench builds the port with its default parameters: 64 words of four 9-bit lanes. It limits random addresses to the lowest eight words, so reads often hit a word that a recent partial write has just changed. Each latency mode is run in its own reset phase, so both the direct path and the registered path face the same mix of partial writes, deselects, lane-masked reads and output-enable pulses. Directed cases cover a read right after a write to the same word, a read with every lane unselected, and the output enable toggling in the middle of a read window.

// File: rtl/sync_mem_pkg.sv
package sync_mem_pkg;
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } mem_op_e;
endpackage

// File: rtl/sync_mem_in_reg.sv
module sync_mem_in_reg
  import sync_mem_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_ni,
  input  logic              we_ni,
  input  logic [LANES-1:0]  sel_ni,
  input  logic [ADDR_W-1:0] addr_i,
  output mem_op_e           op_o,
  output logic [LANES-1:0]  lane_o,
  output logic [ADDR_W-1:0] addr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_o   <= OP_IDLE;
      lane_o <= '0;
      addr_o <= '0;
    end else begin
      if (ce_ni)      op_o <= OP_IDLE;
      else if (we_ni) op_o <= OP_READ;
      else            op_o <= OP_WRITE;
      lane_o <= ~sel_ni;
      addr_o <= addr_i;
    end
  end
endmodule

// File: rtl/sync_mem_array.sv
module sync_mem_array #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int DATA_W = LANES * LANE_W,
  localparam int DEPTH  = 1 << ADDR_W
) (
  input  logic              clk_i,
  input  logic              wr_i,
  input  logic [LANES-1:0]  lane_we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] bank [DEPTH];

    always_ff @(posedge clk_i) begin
      if (wr_i && lane_we_i[l]) bank[waddr_i] <= wdata_i[l*LANE_W +: LANE_W];
    end

    assign rdata_o[l*LANE_W +: LANE_W] = bank[raddr_i];
  end
endmodule

// File: rtl/sync_mem_out_stage.sv
module sync_mem_out_stage #(
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pipe_mode_i,
  input  logic [DATA_W-1:0] rd_word_i,
  input  logic [LANES-1:0]  rd_lane_i,
  input  logic              oe_ni,
  output logic [DATA_W-1:0] rdata_o,
  output logic [DATA_W-1:0] rdata_en_o
);
  logic [DATA_W-1:0] word_q;
  logic [LANES-1:0]  lane_q;
  logic [DATA_W-1:0] word_sel;
  logic [LANES-1:0]  lane_sel;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q <= '0;
      lane_q <= '0;
    end else begin
      word_q <= rd_word_i;
      lane_q <= rd_lane_i;
    end
  end

  assign word_sel = pipe_mode_i ? word_q : rd_word_i;
  assign lane_sel = pipe_mode_i ? lane_q : rd_lane_i;

  for (genvar l = 0; l < LANES; l++) begin : g_drv
    logic lane_on;
    assign lane_on = lane_sel[l] & ~oe_ni;
    assign rdata_en_o[l*LANE_W +: LANE_W] = {LANE_W{lane_on}};
    assign rdata_o[l*LANE_W +: LANE_W]    = lane_on ? word_sel[l*LANE_W +: LANE_W] : '0;
  end
endmodule

// File: rtl/sync_mem_port.sv
module sync_mem_port
  import sync_mem_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pipe_mode_i,
  input  logic              ce_ni,
  input  logic              we_ni,
  input  logic [LANES-1:0]  sel_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              oe_ni,
  output logic [DATA_W-1:0] rdata_o,
  output logic [DATA_W-1:0] rdata_en_o
);
  mem_op_e           op_q;
  logic [LANES-1:0]  lane_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] array_rd;
  logic [LANES-1:0]  rd_lane;
  logic              wr_now;

  // write lands in the array at the sampling edge itself
  assign wr_now = ~ce_ni & ~we_ni;

  sync_mem_in_reg #(.ADDR_W(ADDR_W), .LANES(LANES)) u_in_reg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ce_ni  (ce_ni),
    .we_ni  (we_ni),
    .sel_ni (sel_ni),
    .addr_i (addr_i),
    .op_o   (op_q),
    .lane_o (lane_q),
    .addr_o (addr_q)
  );

  sync_mem_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
    .clk_i     (clk_i),
    .wr_i      (wr_now),
    .lane_we_i (~sel_ni),
    .waddr_i   (addr_i),
    .wdata_i   (wdata_i),
    .raddr_i   (addr_q),
    .rdata_o   (array_rd)
  );

  assign rd_lane = (op_q == OP_READ) ? lane_q : '0;

  sync_mem_out_stage #(.LANES(LANES), .LANE_W(LANE_W)) u_out (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .pipe_mode_i (pipe_mode_i),
    .rd_word_i   (array_rd),
    .rd_lane_i   (rd_lane),
    .oe_ni       (oe_ni),
    .rdata_o     (rdata_o),
    .rdata_en_o  (rdata_en_o)
  );
endmodule

// File: rtl/sync_mem_port_chk.sv
module sync_mem_port_chk #(
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int DATA_W = LANES * LANE_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              pipe_mode_i,
  input logic              ce_ni,
  input logic              we_ni,
  input logic [LANES-1:0]  sel_ni,
  input logic              oe_ni,
  input logic [DATA_W-1:0] rdata_o,
  input logic [DATA_W-1:0] rdata_en_o
);
  logic [1:0] edges_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              edges_q <= '0;
    else if (edges_q != 2'd3) edges_q <= edges_q + 2'd1;
  end

  function automatic logic [DATA_W-1:0] widen(input logic [LANES-1:0] l);
    logic [DATA_W-1:0] w;
    for (int i = 0; i < LANES; i++) w[i*LANE_W +: LANE_W] = {LANE_W{l[i]}};
    return w;
  endfunction

  always @(posedge clk_i) begin
    if (!rst_ni) assert_reset_quiet_R8: assert (rdata_en_o == '0);
  end

  assert_undriven_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdata_o & ~rdata_en_o) == '0);

  assert_oe_blank_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_ni |-> (rdata_en_o == '0 && rdata_o == '0));

  assert_flow_deselect_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pipe_mode_i && edges_q >= 2'd1 && $past(ce_ni)) |-> rdata_en_o == '0);

  assert_pipe_deselect_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pipe_mode_i && edges_q >= 2'd2 && $past(ce_ni, 2)) |-> rdata_en_o == '0);

  assert_flow_write_blank_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pipe_mode_i && edges_q >= 2'd1 && $past(!ce_ni && !we_ni)) |-> rdata_en_o == '0);

  assert_pipe_write_blank_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pipe_mode_i && edges_q >= 2'd2 && $past(!ce_ni && !we_ni, 2)) |-> rdata_en_o == '0);

  // R1 with R4: flow-through read drives exactly the selected lanes next window
  assert_flow_lanes_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pipe_mode_i && !oe_ni && edges_q >= 2'd1 && $past(!ce_ni && we_ni))
      |-> rdata_en_o == widen(~$past(sel_ni)));

  // R2 with R4: pipelined read drives them one window later
  assert_pipe_lanes_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pipe_mode_i && !oe_ni && edges_q >= 2'd2 && $past(!ce_ni && we_ni, 2))
      |-> rdata_en_o == widen(~$past(sel_ni, 2)));
endmodule

bind sync_mem_port sync_mem_port_chk #(.LANES(LANES), .LANE_W(LANE_W)) u_chk (.*);

// File: tb/sync_mem_port_bench.sv
module sync_mem_port_bench;
  localparam int ADDR_W = 6;
  localparam int LANES  = 4;
  localparam int LANE_W = 9;
  localparam int DW     = LANES * LANE_W;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              pipe_mode = 1'b0;
  logic              ce_n = 1'b1;
  logic              we_n = 1'b1;
  logic [LANES-1:0]  sel_n = '1;
  logic [ADDR_W-1:0] addr = '0;
  logic [DW-1:0]     wdata = '0;
  logic              oe_n = 1'b0;
  logic [DW-1:0]     rdata, rdata_en;

  always #10 clk = ~clk;

  sync_mem_port #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_sync_mem_port (
    .clk_i(clk), .rst_ni(rst_n), .pipe_mode_i(pipe_mode), .ce_ni(ce_n), .we_ni(we_n),
    .sel_ni(sel_n), .addr_i(addr), .wdata_i(wdata), .oe_ni(oe_n),
    .rdata_o(rdata), .rdata_en_o(rdata_en)
  );

  logic [DW-1:0] model [1 << ADDR_W];
  logic [DW-1:0] cur_data, cur_en, pend_data, pend_en;
  string         cur_tag, pend_tag;
  int            n_cmp = 0;
  int            n_bad = 0;
  bit            done = 0;

  function automatic logic [DW-1:0] widen(input logic [LANES-1:0] l);
    logic [DW-1:0] w;
    for (int i = 0; i < LANES; i++) w[i*LANE_W +: LANE_W] = {LANE_W{l[i]}};
    return w;
  endfunction

  task automatic check_now(input string tag);
    logic [DW-1:0] m;
    m = oe_n ? '0 : '1;
    n_cmp++;
    if (rdata !== (cur_data & m) || rdata_en !== (cur_en & m)) begin
      n_bad++;
      $display("FAIL %s: data=%h en=%h expected data=%h en=%h", tag,
               rdata, rdata_en, cur_data & m, cur_en & m);
    end
  endtask

  task automatic step(input logic c, input logic w, input logic [LANES-1:0] s,
                      input logic [ADDR_W-1:0] a, input logic [DW-1:0] d,
                      input logic o, input bit probe);
    logic [DW-1:0] r_data, r_en;
    string r_tag;
    @(negedge clk);
    check_now(cur_tag);
    if (probe) begin
      oe_n = 1'b1; #1; check_now("R7 oe high");
      oe_n = 1'b0; #1; check_now("R7 oe low");
    end
    ce_n = c; we_n = w; sel_n = s; addr = a; wdata = d; oe_n = o;
    r_data = '0; r_en = '0;
    if (c)      r_tag = "R5 R9 deselect";
    else if (w) begin
      r_en   = widen(~s);
      r_data = model[a] & r_en;
      r_tag  = pipe_mode ? "R2 R3 R4 read" : "R1 R3 R4 read";
    end else begin
      r_tag = "R6 R9 write";
      for (int l = 0; l < LANES; l++)
        if (!s[l]) model[a][l*LANE_W +: LANE_W] = d[l*LANE_W +: LANE_W];
    end
    if (pipe_mode) begin
      cur_data = pend_data; cur_en = pend_en; cur_tag = pend_tag;
      pend_data = r_data; pend_en = r_en; pend_tag = r_tag;
    end else begin
      cur_data = r_data; cur_en = r_en; cur_tag = r_tag;
    end
  endtask

  task automatic do_reset(input logic mode);
    @(negedge clk);
    rst_n = 1'b0; ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b0; pipe_mode = mode;
    #1;
    cur_data = '0; cur_en = '0; cur_tag = "R8 reset";
    pend_data = '0; pend_en = '0; pend_tag = "R8 reset";
    check_now("R8 in reset");
    repeat (2) @(negedge clk);
    check_now("R8 in reset");
    rst_n = 1'b1;
  endtask

  function automatic logic [DW-1:0] rnd_word();
    return {$urandom, $urandom};
  endfunction

  task automatic run_mode(input logic mode);
    do_reset(mode);
    step(1, 1, '1, 0, '0, 0, 0);
    // R3 preload full words
    for (int i = 0; i < 8; i++) step(0, 0, 4'b0000, ADDR_W'(i), rnd_word(), 0, 0);
    // R3 partial write: only lanes 0 and 2 replaced
    step(0, 0, 4'b1010, 3, {4{9'h1a5}}, 0, 0);
    step(0, 1, 4'b0000, 3, '0, 0, 0);
    // R4 read with no lane selected
    step(0, 1, 4'b1111, 3, '0, 0, 0);
    // R4 single lane read
    step(0, 1, 4'b0111, 3, '0, 0, 0);
    // write then immediate read of same word
    step(0, 0, 4'b0110, 5, rnd_word(), 0, 0);
    step(0, 1, 4'b0000, 5, '0, 0, 0);
    // R5 deselect between reads, then reactivation
    step(1, 1, 4'b0000, 5, '0, 0, 0);
    step(0, 1, 4'b0000, 2, '0, 0, 0);
    step(0, 1, 4'b0000, 1, '0, 0, 0);
    // R7 oe pulse inside read windows
    step(0, 1, 4'b0000, 0, '0, 0, 1);
    step(0, 1, 4'b0000, 4, '0, 0, 1);
    step(0, 1, 4'b0000, 4, '0, 0, 1);
    for (int n = 0; n < 300; n++) begin
      step(($urandom % 6) == 0, $urandom % 2,
           (($urandom % 3) == 0) ? LANES'($urandom) : '0,
           ADDR_W'($urandom % 8), rnd_word(), ($urandom % 10) == 0,
           ($urandom % 25) == 0);
    end
    repeat (3) step(1, 1, '1, 0, '0, 0, 0);
  endtask

  initial begin
    void'($urandom(32'd7341));
    run_mode(1'b0);
    run_mode(1'b1);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule